// File: doc/BRIEF.md
# Floppy Head Seek Sequencer

This block sits on the host side of a stepper-positioned floppy drive and moves the read/write head to a requested track. It drives a drive-select line, a direction line and an active-low step line, and it reads a track-zero sense input. It accepts two commands. A recalibrate command steps outward until track zero is reported. A seek command carries a target track and steps toward it from the value held in its current-track register.

Every timing rule is a parameter counted in system clock cycles. These rules are the step pulse width, the minimum spacing between pulses for the coarse (48 tpi) and fine (96 tpi) track pitches, the minimum high time between pulses, direction setup and hold around the step trailing edge, the settle time after the final step, and the wait after reset. The block never lowers the step line while write gate is active. It ends every accepted command with a one-cycle `done` pulse.

Top module: `head_seek_seq`

## Requirements
- R1: After reset is released, `busy` stays high for POWERUP_CYC cycles. Any command offered in that window is ignored and produces no step pulse. While in reset, `stepN` is 1, `driveSel` is 0, `curTrack` is 0 and `recalErr` is 0.
- R2: Each step pulse holds `stepN` low for at least STEP_LOW_CYC cycles. Falling edges are at least RATE48_CYC cycles apart when `density96`=0 and at least RATE96_CYC cycles apart when it is 1. `stepN` stays high for at least HIGH_MIN_CYC cycles between pulses.
- R3: `dirOut`=1 means outward (toward track 0) and `dirOut`=0 means inward. `dirOut` is stable for at least DIR_SETUP_CYC cycles before each falling edge of `stepN`, throughout the low phase, and for at least DIR_HOLD_CYC cycles after the rising edge.
- R4: A seek (`cmdRecal`=0) to a track different from `curTrack` issues exactly |target − curTrack| pulses. The direction is outward when target < curTrack. `curTrack` equals the target when `done` pulses.
- R5: A seek to the track already in `curTrack` issues no pulse. `done` follows within three cycles of the command being offered.
- R6: `stepN` never falls on a clock edge at which `writeGate` is high. Stepping resumes once `writeGate` drops, and the seek still reaches its target.
- R7: `driveSel` is high whenever `stepN` is low.
- R8: A recalibrate (`cmdRecal`=1) samples `trackZero` before each pulse and steps outward until it reads high. It then clears `curTrack` to 0 with `recalErr`=0. If `trackZero` is already high, no pulse is issued.
- R9: If `trackZero` is still low after MAX_RECAL_STEPS pulses, the recalibrate ends with `recalErr`=1 after exactly that many pulses. If `trackZero` becomes high through the last allowed pulse, the recalibrate succeeds. `recalErr` is cleared when the next command is accepted.
- R10: When a command has stepped, `done` comes at least SETTLE_CYC cycles after the last rising edge of `stepN`. `done` lasts one cycle and `busy` is low on the following cycle.
- R11: `curTrack` changes by exactly one on the edge where `stepN` rises. It decrements for outward steps, saturating at 0, and increments for inward steps.
- R12: A command offered while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Offers a command for one cycle; taken only while idle |
| cmdRecal | input | 1 | 1 = recalibrate, 0 = seek |
| cmdTrack | input | TRACK_W | Target track for a seek |
| density96 | input | 1 | 1 = fine pitch step rate, 0 = coarse pitch step rate |
| writeGate | input | 1 | Write gate active; holds off stepping |
| trackZero | input | 1 | High when the drive reports the head at track 0 |
| driveSel | output | 1 | Drive select, high while a command is moving or settling |
| dirOut | output | 1 | Step direction, 1 = outward |
| stepN | output | 1 | Active-low step pulse; head moves on its rising edge |
| busy | output | 1 | High from reset release through power-up wait and during each command |
| done | output | 1 | One-cycle completion pulse |
| recalErr | output | 1 | Last recalibrate ran out of steps without seeing track 0 |
| curTrack | output | TRACK_W | Current-track register |

## Verification
Two conditions can fall in the same cycle. On the last step a recalibrate is allowed, track zero may appear just as the step counter reaches its limit. The decision state then sees both the step-limit flag and the sense input. The bench provokes this by placing its drive model exactly MAX_RECAL_STEPS tracks out, where success must win with no error flag. It then places the model one track further out, where the error flag must be set after exactly MAX_RECAL_STEPS pulses. A second overlap, write gate rising while a step is about to be issued, is provoked mid-seek. It is judged by finding no falling step edge at any edge where write gate was high, and by the seek still reaching its target.

// File: rtl/seek_pkg.sv
package seek_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_CHECK, ST_SETUP, ST_LOW, ST_GAP, ST_SETTLE, ST_FINISH
  } seqState_t;

  typedef enum logic [1:0] {
    TM_SETUP, TM_LOW, TM_GAP, TM_SETTLE
  } timerSel_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic      timerLoad;
    timerSel_t timerSel;
    logic      cmdLatch;
    logic      dirLoad;
    logic      trkStep;
    logic      trkClear;
    logic      errSet;
  } seqStrobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seek_datapath.sv
module seek_datapath
  import seek_pkg::*;
#(
  parameter int TRACK_W         = 7,
  parameter int STEP_LOW_CYC    = 4,
  parameter int DIR_SETUP_CYC   = 2,
  parameter int DIR_HOLD_CYC    = 2,
  parameter int RATE48_CYC      = 48,
  parameter int RATE96_CYC      = 24,
  parameter int HIGH_MIN_CYC    = 20,
  parameter int SETTLE_CYC      = 60,
  parameter int POWERUP_CYC     = 100,
  parameter int MAX_RECAL_STEPS = 84
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               cmdRecal,
  input  logic [TRACK_W-1:0] cmdTrack,
  input  logic               density96,
  output logic               timerZero,
  output logic               atTarget,
  output logic               recalMode,
  output logic               cntAtMax,
  output logic               hasStepped,
  output logic               dirOut,
  output logic [TRACK_W-1:0] curTrack,
  output logic               recalErr
);

  // High-phase length after the trailing edge, one decision cycle not counted
  localparam int GAP48 = maxInt(DIR_HOLD_CYC,
                         maxInt(HIGH_MIN_CYC - DIR_SETUP_CYC,
                                RATE48_CYC - STEP_LOW_CYC - DIR_SETUP_CYC));
  localparam int GAP96 = maxInt(DIR_HOLD_CYC,
                         maxInt(HIGH_MIN_CYC - DIR_SETUP_CYC,
                                RATE96_CYC - STEP_LOW_CYC - DIR_SETUP_CYC));
  localparam int TIMER_MAX = maxInt(maxInt(POWERUP_CYC, SETTLE_CYC),
                             maxInt(maxInt(GAP48, GAP96),
                                    maxInt(STEP_LOW_CYC, DIR_SETUP_CYC)));
  localparam int TIMER_W = $clog2(TIMER_MAX + 1);
  localparam int CNT_W   = $clog2(MAX_RECAL_STEPS + 1);

  localparam logic [TIMER_W-1:0] LD_PWRUP  = TIMER_W'(POWERUP_CYC - 1);
  localparam logic [TIMER_W-1:0] LD_SETUP  = TIMER_W'(DIR_SETUP_CYC - 1);
  localparam logic [TIMER_W-1:0] LD_LOW    = TIMER_W'(STEP_LOW_CYC - 1);
  localparam logic [TIMER_W-1:0] LD_GAP48  = TIMER_W'(GAP48 - 1);
  localparam logic [TIMER_W-1:0] LD_GAP96  = TIMER_W'(GAP96 - 1);
  localparam logic [TIMER_W-1:0] LD_SETTLE = TIMER_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0]   CNT_LIMIT = CNT_W'(MAX_RECAL_STEPS);

  logic [TIMER_W-1:0] timer, loadVal;
  logic [CNT_W-1:0]   stepCnt;
  logic [TRACK_W-1:0] targetReg;
  logic               denReg;

  always_comb begin
    case (strobe.timerSel)
      TM_SETUP: loadVal = LD_SETUP;
      TM_LOW:   loadVal = LD_LOW;
      TM_GAP:   loadVal = denReg ? LD_GAP96 : LD_GAP48;
      default:  loadVal = LD_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 timer <= LD_PWRUP;
    else if (strobe.timerLoad) timer <= loadVal;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetReg <= '0;
      recalMode <= 1'b0;
      denReg    <= 1'b0;
    end else if (strobe.cmdLatch) begin
      targetReg <= cmdTrack;
      recalMode <= cmdRecal;
      denReg    <= density96;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  dirOut <= 1'b1;
    else if (strobe.dirLoad)    dirOut <= recalMode | (targetReg < curTrack);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  curTrack <= '0;
    else if (strobe.trkClear)   curTrack <= '0;
    else if (strobe.trkStep) begin
      if (dirOut)               curTrack <= (curTrack == '0) ? '0 : curTrack - 1'b1;
      else                      curTrack <= curTrack + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  stepCnt <= '0;
    else if (strobe.cmdLatch)   stepCnt <= '0;
    else if (strobe.trkStep && stepCnt != CNT_LIMIT) stepCnt <= stepCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  recalErr <= 1'b0;
    else if (strobe.cmdLatch)   recalErr <= 1'b0;
    else if (strobe.errSet)     recalErr <= 1'b1;
  end

  assign timerZero  = (timer == '0);
  assign atTarget   = (targetReg == curTrack);
  assign cntAtMax   = (stepCnt == CNT_LIMIT);
  assign hasStepped = (stepCnt != '0);

endmodule

// File: rtl/seek_control.sv
module seek_control
  import seek_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       writeGate,
  input  logic       trackZero,
  input  logic       timerZero,
  input  logic       atTarget,
  input  logic       recalMode,
  input  logic       cntAtMax,
  input  logic       hasStepped,
  output seqStrobe_t strobe,
  output logic       stepN,
  output logic       driveSel,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;
  logic      finishing;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PWRUP;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    // Track zero outranks the step limit when both hold in the same cycle
    finishing = recalMode ? (trackZero | cntAtMax) : atTarget;
    case (state)
      ST_PWRUP: if (timerZero) nextState = ST_IDLE;
      ST_IDLE: if (cmdValid) begin
        strobe.cmdLatch = 1'b1;
        nextState       = ST_CHECK;
      end
      ST_CHECK: begin
        if (finishing) begin
          if (recalMode && trackZero) strobe.trkClear = 1'b1;
          else if (recalMode)         strobe.errSet   = 1'b1;
          if (hasStepped) begin
            strobe.timerLoad = 1'b1;
            strobe.timerSel  = TM_SETTLE;
            nextState        = ST_SETTLE;
          end else begin
            nextState = ST_FINISH;
          end
        end else if (!writeGate) begin
          strobe.dirLoad   = 1'b1;
          strobe.timerLoad = 1'b1;
          strobe.timerSel  = TM_SETUP;
          nextState        = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (writeGate) begin
          nextState = ST_CHECK;
        end else if (timerZero) begin
          strobe.timerLoad = 1'b1;
          strobe.timerSel  = TM_LOW;
          nextState        = ST_LOW;
        end
      end
      ST_LOW: if (timerZero) begin
        strobe.trkStep   = 1'b1;
        strobe.timerLoad = 1'b1;
        strobe.timerSel  = TM_GAP;
        nextState        = ST_GAP;
      end
      ST_GAP:    if (timerZero) nextState = ST_CHECK;
      ST_SETTLE: if (timerZero) nextState = ST_FINISH;
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign stepN    = (state != ST_LOW);
  assign driveSel = (state == ST_CHECK) || (state == ST_SETUP) || (state == ST_LOW) ||
                    (state == ST_GAP)   || (state == ST_SETTLE);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);

endmodule

// File: rtl/head_seek_seq.sv
module head_seek_seq
  import seek_pkg::*;
#(
  parameter int TRACK_W         = 7,
  parameter int STEP_LOW_CYC    = 4,
  parameter int DIR_SETUP_CYC   = 2,
  parameter int DIR_HOLD_CYC    = 2,
  parameter int RATE48_CYC      = 48,
  parameter int RATE96_CYC      = 24,
  parameter int HIGH_MIN_CYC    = 20,
  parameter int SETTLE_CYC      = 60,
  parameter int POWERUP_CYC     = 100,
  parameter int MAX_RECAL_STEPS = 84
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic               cmdRecal,
  input  logic [TRACK_W-1:0] cmdTrack,
  input  logic               density96,
  input  logic               writeGate,
  input  logic               trackZero,
  output logic               driveSel,
  output logic               dirOut,
  output logic               stepN,
  output logic               busy,
  output logic               done,
  output logic               recalErr,
  output logic [TRACK_W-1:0] curTrack
);

  seqStrobe_t strobe;
  logic timerZero, atTarget, recalMode, cntAtMax, hasStepped;

  seek_control u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .writeGate(writeGate),
    .trackZero(trackZero), .timerZero(timerZero), .atTarget(atTarget),
    .recalMode(recalMode), .cntAtMax(cntAtMax), .hasStepped(hasStepped),
    .strobe(strobe), .stepN(stepN), .driveSel(driveSel), .busy(busy), .done(done)
  );

  seek_datapath #(
    .TRACK_W(TRACK_W), .STEP_LOW_CYC(STEP_LOW_CYC), .DIR_SETUP_CYC(DIR_SETUP_CYC),
    .DIR_HOLD_CYC(DIR_HOLD_CYC), .RATE48_CYC(RATE48_CYC), .RATE96_CYC(RATE96_CYC),
    .HIGH_MIN_CYC(HIGH_MIN_CYC), .SETTLE_CYC(SETTLE_CYC), .POWERUP_CYC(POWERUP_CYC),
    .MAX_RECAL_STEPS(MAX_RECAL_STEPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdRecal(cmdRecal), .cmdTrack(cmdTrack),
    .density96(density96), .timerZero(timerZero), .atTarget(atTarget),
    .recalMode(recalMode), .cntAtMax(cntAtMax), .hasStepped(hasStepped),
    .dirOut(dirOut), .curTrack(curTrack), .recalErr(recalErr)
  );

endmodule

// File: rtl/seek_checker.sv
module seek_checker #(
  parameter int STEP_LOW_CYC = 4,
  parameter int RATE_MIN_CYC = 24
) (
  input logic clk,
  input logic rstN,
  input logic stepN,
  input logic dirOut,
  input logic driveSel,
  input logic writeGate,
  input logic busy,
  input logic done
);

  logic        prevStepN, seenFall;
  logic [15:0] lowCnt, sinceFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStepN <= 1'b1;
      seenFall  <= 1'b0;
      lowCnt    <= '0;
      sinceFall <= '0;
    end else begin
      prevStepN <= stepN;
      if (stepN)                 lowCnt <= '0;
      else if (lowCnt != '1)     lowCnt <= lowCnt + 1'b1;
      if (prevStepN && !stepN) begin
        sinceFall <= 16'd1;
        seenFall  <= 1'b1;
      end else if (sinceFall != '1) begin
        sinceFall <= sinceFall + 1'b1;
      end
    end
  end

  assert_step_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stepN && !prevStepN) |-> (lowCnt >= 16'(STEP_LOW_CYC)));

  assert_step_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stepN && prevStepN && seenFall) |-> (sinceFall >= 16'(RATE_MIN_CYC)));

  assert_dir_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stepN || !prevStepN) |-> $stable(dirOut));

  assert_no_step_in_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stepN && prevStepN) |-> !$past(writeGate));

  assert_select_on_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stepN |-> driveSel);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

bind head_seek_seq seek_checker #(
  .STEP_LOW_CYC(STEP_LOW_CYC),
  .RATE_MIN_CYC((RATE96_CYC < RATE48_CYC) ? RATE96_CYC : RATE48_CYC)
) u_seekChk (
  .clk(clk), .rstN(rstN), .stepN(stepN), .dirOut(dirOut), .driveSel(driveSel),
  .writeGate(writeGate), .busy(busy), .done(done)
);

// File: tb/test_head_seek_seq.sv
module test_head_seek_seq;

  localparam int TW       = 7;
  localparam int LOWC     = 4;
  localparam int SETUPC   = 2;
  localparam int HOLDC    = 2;
  localparam int R48      = 48;
  localparam int R96      = 24;
  localparam int HIGHC    = 20;
  localparam int SETTLEC  = 60;
  localparam int PWRC     = 100;
  localparam int MAXSTEPS = 84;

  typedef struct packed {
    logic       recal;
    logic [6:0] trk;
    logic       den;
    logic [7:0] steps;
    logic       dir;
    logic [6:0] endTrk;
    logic       err;
    logic [7:0] startPos;   // 255 = leave the drive model where it is
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 7'd0,  1'b0, 8'd37, 1'b1, 7'd0,  1'b0, 8'd37},
    '{1'b0, 7'd10, 1'b0, 8'd10, 1'b0, 7'd10, 1'b0, 8'd255},
    '{1'b0, 7'd10, 1'b1, 8'd0,  1'b0, 7'd10, 1'b0, 8'd255},
    '{1'b0, 7'd3,  1'b1, 8'd7,  1'b1, 7'd3,  1'b0, 8'd255},
    '{1'b0, 7'd79, 1'b1, 8'd76, 1'b0, 7'd79, 1'b0, 8'd255},
    '{1'b0, 7'd0,  1'b0, 8'd79, 1'b1, 7'd0,  1'b0, 8'd255},
    '{1'b1, 7'd0,  1'b1, 8'd84, 1'b1, 7'd0,  1'b0, 8'd84},
    '{1'b1, 7'd0,  1'b1, 8'd84, 1'b1, 7'd0,  1'b1, 8'd85},
    '{1'b1, 7'd0,  1'b0, 8'd1,  1'b1, 7'd0,  1'b0, 8'd255},
    '{1'b1, 7'd0,  1'b0, 8'd0,  1'b1, 7'd0,  1'b0, 8'd255}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRecal = 1'b0, density96 = 1'b0, writeGate = 1'b0;
  logic [TW-1:0] cmdTrack = '0;
  logic trackZero, driveSel, dirOut, stepN, busy, done, recalErr;
  logic [TW-1:0] curTrack;

  always #4 clk = ~clk;

  head_seek_seq #(
    .TRACK_W(TW), .STEP_LOW_CYC(LOWC), .DIR_SETUP_CYC(SETUPC), .DIR_HOLD_CYC(HOLDC),
    .RATE48_CYC(R48), .RATE96_CYC(R96), .HIGH_MIN_CYC(HIGHC), .SETTLE_CYC(SETTLEC),
    .POWERUP_CYC(PWRC), .MAX_RECAL_STEPS(MAXSTEPS)
  ) i_head_seek_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRecal(cmdRecal), .cmdTrack(cmdTrack),
    .density96(density96), .writeGate(writeGate), .trackZero(trackZero),
    .driveSel(driveSel), .dirOut(dirOut), .stepN(stepN), .busy(busy), .done(done),
    .recalErr(recalErr), .curTrack(curTrack)
  );

  // Drive model and monitor state (written only by the monitor)
  int pos = 0;
  int cyc = 0;
  int nFall, nRise, nDone, minLow, minIntv, minHigh, lastFall, lastRise, lastDirChg = -1000;
  int dirViol, dirMis, trkViol, wgViol, selViol, settleSeen, doneCyc;
  int posLoadSeen = 0, cmdSeen = 0;
  logic prevStep = 1'b1, prevDir = 1'b1, prevWg = 1'b0;
  int prevCur = 0;

  // Written only by the main sequence
  int posLoadSeq = 0, posLoadVal = 0, cmdSeq = 0, issueCyc = 0;
  logic expDirVal = 1'b1;
  int nCheck = 0, nBad = 0;
  bit finished = 1'b0;

  assign trackZero = (pos == 0);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (posLoadSeq != posLoadSeen) begin
      pos = posLoadVal;
      posLoadSeen = posLoadSeq;
    end
    if (cmdSeq != cmdSeen) begin
      cmdSeen = cmdSeq;
      nFall = 0; nRise = 0; nDone = 0; minLow = 9999; minIntv = 9999; minHigh = 9999;
      lastFall = -1; lastRise = -1; dirViol = 0; dirMis = 0; trkViol = 0;
      wgViol = 0; selViol = 0; settleSeen = -1; doneCyc = -1;
    end
    if (rstN) begin
      if (prevStep && !stepN) begin
        nFall = nFall + 1;
        if (prevWg) wgViol = wgViol + 1;
        if (!driveSel) selViol = selViol + 1;
        if (dirOut !== expDirVal) dirMis = dirMis + 1;
        if (lastFall >= 0 && cyc - lastFall < minIntv) minIntv = cyc - lastFall;
        if (lastRise >= 0 && cyc - lastRise < minHigh) minHigh = cyc - lastRise;
        lastFall = cyc;
      end
      if (!prevStep && stepN) begin
        nRise = nRise + 1;
        if (cyc - lastFall < minLow) minLow = cyc - lastFall;
        if (cyc - lastDirChg < SETUPC + LOWC) dirViol = dirViol + 1;
        if (dirOut) begin
          if (int'(curTrack) != ((prevCur == 0) ? 0 : prevCur - 1)) trkViol = trkViol + 1;
          if (pos > 0) pos = pos - 1;
        end else begin
          if (int'(curTrack) != prevCur + 1) trkViol = trkViol + 1;
          pos = pos + 1;
        end
        lastRise = cyc;
      end
      if (dirOut !== prevDir) begin
        if (lastRise >= 0 && cyc - lastRise < HOLDC) dirViol = dirViol + 1;
        lastDirChg = cyc;
      end
      if (done) begin
        nDone = nDone + 1;
        doneCyc = cyc;
        if (lastRise >= 0) settleSeen = cyc - lastRise;
      end
    end
    prevStep = stepN; prevDir = dirOut; prevWg = writeGate; prevCur = int'(curTrack);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setPos(input int p);
    posLoadVal = p;
    posLoadSeq++;
    @(posedge clk); #1;
  endtask

  task automatic issue(input bit rc, input int trk, input bit den);
    cmdSeq++;
    issueCyc = cyc;
    cmdValid = 1'b1; cmdRecal = rc; cmdTrack = TW'(trk); density96 = den;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(input int lim);
    for (int i = 0; i < lim && nDone == 0; i++) @(posedge clk);
    #1;
  endtask

  task automatic runCmd(input vec_t v);
    int rate;
    rate = v.den ? R96 : R48;
    expDirVal = v.dir;
    if (v.startPos != 8'd255) setPos(int'(v.startPos));
    issue(v.recal, int'(v.trk), v.den);
    waitDone(20000);
    check(nFall == int'(v.steps), "R4/R8/R9 pulse count", nFall, int'(v.steps));
    check(int'(curTrack) == int'(v.endTrk), "R4/R8 final curTrack", int'(curTrack), int'(v.endTrk));
    check(recalErr == v.err, "R9 recalErr", int'(recalErr), int'(v.err));
    check(nDone == 1 && busy == 1'b0, "R10 single done then idle", nDone, 1);
    if (v.steps != 0) begin
      check(minLow >= LOWC, "R2 low width", minLow, LOWC);
      check(settleSeen >= SETTLEC, "R10 settle", settleSeen, SETTLEC);
      check(dirMis == 0, "R3/R4 direction sign", dirMis, 0);
      check(dirViol == 0, "R3 direction setup/hold", dirViol, 0);
      check(trkViol == 0, "R11 curTrack per pulse", trkViol, 0);
      check(selViol == 0, "R7 select during pulse", selViol, 0);
      if (v.steps > 1) begin
        check(minIntv >= rate, "R2 pulse spacing", minIntv, rate);
        check(minHigh >= HIGHC, "R2 high time", minHigh, HIGHC);
      end
    end else begin
      check(doneCyc - issueCyc <= 3, "R5 immediate done", doneCyc - issueCyc, 3);
    end
  endtask

  initial begin
    int f0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(stepN == 1'b1, "R1 stepN in reset", int'(stepN), 1);
    check(driveSel == 1'b0, "R1 driveSel in reset", int'(driveSel), 0);
    check(curTrack == '0, "R1 curTrack in reset", int'(curTrack), 0);
    check(recalErr == 1'b0, "R1 recalErr in reset", int'(recalErr), 0);
    rstN = 1'b1;
    cmdSeq++;
    setPos(37);
    repeat (5) @(posedge clk);
    #1;
    // R1 command offered during the power-up wait is ignored
    cmdValid = 1'b1; cmdRecal = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cmdValid = 1'b0;
    repeat (PWRC - 20) @(posedge clk);
    #1;
    check(busy == 1'b1, "R1 busy during power-up", int'(busy), 1);
    repeat (25) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1 idle after power-up", int'(busy), 0);
    check(nFall == 0 && nDone == 0, "R1 power-up command ignored", nFall + nDone, 0);

    // Table of commands
    for (int k = 0; k < NVEC; k++) runCmd(VECS[k]);

    // R6 write gate holds off stepping mid-seek (track 0 -> 20)
    expDirVal = 1'b0;
    issue(1'b0, 20, 1'b1);
    for (int i = 0; i < 5000 && nFall < 3; i++) @(posedge clk);
    #1;
    writeGate = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    f0 = nFall;
    repeat (150) @(posedge clk);
    #1;
    check(nFall == f0, "R6 no pulse while write gate high", nFall, f0);
    check(busy == 1'b1, "R6 still busy while held", int'(busy), 1);
    writeGate = 1'b0;
    waitDone(20000);
    check(wgViol == 0, "R6 fall under write gate", wgViol, 0);
    check(nFall == 20 && int'(curTrack) == 20, "R6 seek completes after release",
          int'(curTrack), 20);

    // R12 command offered while busy is ignored (20 -> 30, then an attempt at 5)
    expDirVal = 1'b0;
    issue(1'b0, 30, 1'b1);
    repeat (20) @(posedge clk);
    #1;
    cmdValid = 1'b1; cmdRecal = 1'b0; cmdTrack = TW'(5);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    waitDone(20000);
    check(int'(curTrack) == 30, "R12 busy command ignored, track", int'(curTrack), 30);
    check(nFall == 10, "R12 busy command ignored, pulses", nFall, 10);
    f0 = nFall;
    repeat (100) @(posedge clk);
    #1;
    check(nFall == f0 && busy == 1'b0, "R12 no late activity", nFall, f0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nCheck, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", nCheck + 1, nBad + 1);
      $finish;
    end
  end

endmodule